// File: doc/BRIEF.md
# CAN Frame Acceptance Filter

This block decides whether a received CAN frame is kept or dropped. Eight configuration bytes, four code bytes and four mask bytes, describe the frames of interest. In a mask, a bit set to 1 marks the matching code bit as "don't care". One mode input picks how the bytes are used. Single mode builds one long filter that covers the identifier, the remote-request flag and, for standard frames, up to two data bytes. Dual mode builds two shorter filters, and a frame passes if either of them hits.

The frame is given as an identifier, an extended flag, a remote-request flag, a data length code and the first two data bytes, with a valid strobe. The match itself is combinational. It is registered once, so the verdict appears on the cycle after the strobe. The code and mask words are flat 32-bit ports. Configuration byte k sits at bits [31-8k : 24-8k], so byte 0 occupies [31:24] and byte 3 occupies [7:0].

Top module: `can_accept_filter`

## Requirements
- R1: In the cycle after a clock edge that samples frameValid, verdictValid equals the sampled frameValid. verdictAccept is 0 whenever verdictValid is 0. Both outputs are 0 during reset.
- R2: A mask bit of 1 removes the matching code bit from every comparison. With filtMask all ones, every frame is accepted in either mode.
- R3: In single mode, an extended frame compares ID[28:0] with {byte0, byte1, byte2, byte3[7:3]} and compares RTR with byte3[2]. The mask uses the same layout, and the data bytes are not checked.
- R4: In single mode, a standard frame compares ID[10:0] with {byte0, byte1[7:5]} and compares RTR with byte1[4]. byte1[3:0] is not used. If the identifier matches and the frame is remote or has DLC 0, the frame is accepted with no data check.
- R5: In single mode, a standard data frame with DLC of 1 or more also requires data byte 0 to match byte2 under mask byte2. With DLC 1, data byte 1 is ignored. With DLC 2 or more, data byte 1 must also match byte3 under mask byte3.
- R6: In dual mode, an extended frame compares only ID[28:13]. Filter A uses {byte0, byte1} and filter B uses {byte2, byte3}. The frame is accepted if either filter hits. ID[12:0] and RTR are ignored.
- R7: In dual mode, filter A for a standard frame matches ID and RTR exactly as in R4. It also requires data byte 0 to match {byte1[3:0], byte3[3:0]}, with the mask built the same way. This data check passes when the frame carries no data, that is, when it is remote or has DLC 0.
- R8: In dual mode, filter B for a standard frame compares ID[10:0] with {byte2, byte3[7:5]} and compares RTR with byte3[4]. It never checks data. The frame is accepted if filter A or filter B hits.
- R9: singleMode = 1 selects single-filter mode and singleMode = 0 selects dual-filter mode. The same code bytes give different verdicts in the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleMode | input | 1 | 1 selects the single long filter, 0 selects two short filters |
| filtCode | input | 32 | Code bytes 0..3, with byte 0 in the top byte |
| filtMask | input | 32 | Mask bytes 0..3 in the same layout; 1 means don't care |
| frameValid | input | 1 | A frame is presented this cycle |
| frameExt | input | 1 | 1 for a 29-bit identifier, 0 for an 11-bit identifier |
| frameRtr | input | 1 | Remote-request flag |
| frameId | input | 29 | Identifier; a standard frame uses bits [10:0] |
| frameDlc | input | 4 | Data length code |
| frameData0 | input | 8 | First data byte |
| frameData1 | input | 8 | Second data byte |
| verdictValid | output | 1 | A verdict is presented, one cycle after frameValid |
| verdictAccept | output | 1 | The frame was accepted |

## Verification
The bench targets the places where a layout slip stays hidden on ordinary traffic.

- **Standard-frame identifier bits:** a design that took the three low identifier bits from the wrong end of byte 1 rejects a frame whose ID differs from the code only there.
- **DLC 0 and DLC 1 shortcuts:**
  - A design that always checked data byte 1 rejects a one-byte frame carrying a mismatching second byte.
  - One that checked data on remote or empty frames drops them.
- **Split nibble in dual mode:** swapping the two halves of the data byte that is assembled from byte 1 and byte 3 flips the verdict of the nibble test.
- **Dual extended filters:** the test that filter B alone can accept catches a design that ignored filter B.
- **Dual extended RTR:** a remote frame that matches filter B must still be accepted, which catches a design that compared RTR there.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_CFG  = 4;
  localparam int CFG_W    = BYTE_W * NUM_CFG;
  localparam int EXT_ID_W = 29;
  localparam int STD_ID_W = 11;
  localparam int DLC_W    = 4;
  localparam int DUAL_EXT_LSB = 13;
  localparam int DUAL_EXT_W   = EXT_ID_W - DUAL_EXT_LSB;

  typedef struct packed {
    logic singleExt;
    logic singleStd;
    logic dualExt;
    logic dualStd;
    logic needData0;
    logic needData1;
    logic dualDataChk;
  } fltStrobe_t;
endpackage

// File: rtl/can_flt_ctrl.sv
module can_flt_ctrl
  import can_flt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             singleMode,
  input  logic             frameExt,
  input  logic             frameRtr,
  input  logic [DLC_W-1:0] frameDlc,
  output fltStrobe_t       strb
);
  logic noData;
  assign noData = frameRtr || (frameDlc == '0);

  always_comb begin
    strb = '0;
    if (singleMode) begin
      strb.singleExt = frameExt;
      strb.singleStd = !frameExt;
      strb.needData0 = !frameExt && !noData;
      strb.needData1 = !frameExt && !noData && (frameDlc >= DLC_W'(2));
    end else begin
      strb.dualExt     = frameExt;
      strb.dualStd     = !frameExt;
      strb.dualDataChk = !frameExt && !noData;
    end
  end

  // R5: the second data byte is checked only when the first one is checked too
  a_r5_data1_after_data0: assert property (@(posedge clk) disable iff (!rstN)
    strb.needData1 |-> strb.needData0);

  // R9: the mode input picks exactly one comparison path
  a_r9_one_path: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strb.singleExt, strb.singleStd, strb.dualExt, strb.dualStd}));
endmodule

// File: rtl/can_flt_dp.sv
module can_flt_dp
  import can_flt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fltStrobe_t          strb,
  input  logic [CFG_W-1:0]    filtCode,
  input  logic [CFG_W-1:0]    filtMask,
  input  logic                frameValid,
  input  logic                frameRtr,
  input  logic [EXT_ID_W-1:0] frameId,
  input  logic [BYTE_W-1:0]   frameData0,
  input  logic [BYTE_W-1:0]   frameData1,
  output logic                verdictValid,
  output logic                verdictAccept
);
  logic [BYTE_W-1:0] cB [NUM_CFG];
  logic [BYTE_W-1:0] mB [NUM_CFG];

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_bytes
    assign cB[k] = filtCode[CFG_W-1-BYTE_W*k -: BYTE_W];
    assign mB[k] = filtMask[CFG_W-1-BYTE_W*k -: BYTE_W];
  end

  logic unusedLowBits;
  assign unusedLowBits = ^{cB[3][1:0], mB[3][1:0]};

  // single, extended frame
  logic [EXT_ID_W-1:0] seCode, seMask;
  logic seHit;
  assign seCode = {cB[0], cB[1], cB[2], cB[3][7:3]};
  assign seMask = {mB[0], mB[1], mB[2], mB[3][7:3]};
  assign seHit  = (((frameId ^ seCode) & ~seMask) == '0) &&
                  !((frameRtr ^ cB[3][2]) && !mB[3][2]);

  // standard identifier through bytes 0/1 (single mode and dual filter A)
  logic [STD_ID_W-1:0] stdIdA, stdMaskA, stdIdB, stdMaskB;
  logic stdHitA, stdHitB;
  assign stdIdA   = {cB[0], cB[1][7:5]};
  assign stdMaskA = {mB[0], mB[1][7:5]};
  assign stdHitA  = (((frameId[STD_ID_W-1:0] ^ stdIdA) & ~stdMaskA) == '0) &&
                    !((frameRtr ^ cB[1][4]) && !mB[1][4]);
  assign stdIdB   = {cB[2], cB[3][7:5]};
  assign stdMaskB = {mB[2], mB[3][7:5]};
  assign stdHitB  = (((frameId[STD_ID_W-1:0] ^ stdIdB) & ~stdMaskB) == '0) &&
                    !((frameRtr ^ cB[3][4]) && !mB[3][4]);

  // data comparisons
  logic d0Hit, d1Hit, dualDataHit;
  logic [BYTE_W-1:0] dualDataCode, dualDataMask;
  assign d0Hit = ((frameData0 ^ cB[2]) & ~mB[2]) == '0;
  assign d1Hit = ((frameData1 ^ cB[3]) & ~mB[3]) == '0;
  assign dualDataCode = {cB[1][3:0], cB[3][3:0]};
  assign dualDataMask = {mB[1][3:0], mB[3][3:0]};
  assign dualDataHit  = ((frameData0 ^ dualDataCode) & ~dualDataMask) == '0;

  // dual, extended frame
  logic deHitA, deHitB;
  logic [DUAL_EXT_W-1:0] idTop;
  assign idTop  = frameId[EXT_ID_W-1:DUAL_EXT_LSB];
  assign deHitA = ((idTop ^ {cB[0], cB[1]}) & ~{mB[0], mB[1]}) == '0;
  assign deHitB = ((idTop ^ {cB[2], cB[3]}) & ~{mB[2], mB[3]}) == '0;

  logic ssOk, dsHitA, acceptNow;
  assign ssOk   = stdHitA && (!strb.needData0 || d0Hit) && (!strb.needData1 || d1Hit);
  assign dsHitA = stdHitA && (!strb.dualDataChk || dualDataHit);

  assign acceptNow = (strb.singleExt && seHit) ||
                     (strb.singleStd && ssOk)  ||
                     (strb.dualExt   && (deHitA || deHitB)) ||
                     (strb.dualStd   && (dsHitA || stdHitB));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
    end else begin
      verdictValid  <= frameValid;
      verdictAccept <= frameValid && acceptNow;
    end
  end

  // R1: the verdict strobe follows the frame strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> verdictValid == $past(frameValid));

  // R1: no acceptance without a verdict
  a_r1_accept_gated: assert property (@(posedge clk) disable iff (!rstN)
    verdictAccept |-> verdictValid);

  // R6: a dual extended hit in either filter must show up as acceptance
  a_r6_dual_ext_hit: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && strb.dualExt && (deHitA || deHitB)) |=> verdictAccept);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                singleMode,
  input  logic [CFG_W-1:0]    filtCode,
  input  logic [CFG_W-1:0]    filtMask,
  input  logic                frameValid,
  input  logic                frameExt,
  input  logic                frameRtr,
  input  logic [EXT_ID_W-1:0] frameId,
  input  logic [DLC_W-1:0]    frameDlc,
  input  logic [BYTE_W-1:0]   frameData0,
  input  logic [BYTE_W-1:0]   frameData1,
  output logic                verdictValid,
  output logic                verdictAccept
);
  fltStrobe_t strb;

  can_flt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .singleMode(singleMode),
    .frameExt(frameExt), .frameRtr(frameRtr), .frameDlc(frameDlc),
    .strb(strb)
  );

  can_flt_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .filtCode(filtCode), .filtMask(filtMask),
    .frameValid(frameValid), .frameRtr(frameRtr), .frameId(frameId),
    .frameData0(frameData0), .frameData1(frameData1),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );

  // R2: an all-ones mask accepts any frame
  a_r2_all_dontcare: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && (filtMask == '1)) |=> verdictAccept);
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        sm;
    logic [31:0] code;
    logic [31:0] mask;
    logic        ext;
    logic        rtr;
    logic [28:0] id;
    logic [3:0]  dlc;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    // R3 single extended
    '{1'b1, 32'hA53C9658, 32'h00000000, 1'b1, 1'b0, 29'h14A792CB, 4'd0, 8'h00, 8'h00, 1'b1, 8'd3},
    '{1'b1, 32'hA53C9658, 32'h00000000, 1'b1, 1'b0, 29'h14A792CA, 4'd0, 8'h00, 8'h00, 1'b0, 8'd3},
    '{1'b1, 32'hA53C9658, 32'h00000000, 1'b1, 1'b1, 29'h14A792CB, 4'd0, 8'h00, 8'h00, 1'b0, 8'd3},
    '{1'b1, 32'hA53C9658, 32'h00000004, 1'b1, 1'b1, 29'h14A792CB, 4'd0, 8'h00, 8'h00, 1'b1, 8'd3},
    '{1'b1, 32'hA53C9658, 32'h000000F8, 1'b1, 1'b0, 29'h14A792C0, 4'd8, 8'h5A, 8'hA5, 1'b1, 8'd3},
    // R4 / R5 single standard
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd2, 8'h11, 8'h22, 1'b1, 8'd5},
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd2, 8'h11, 8'h23, 1'b0, 8'd5},
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd1, 8'h11, 8'hFF, 1'b1, 8'd5},
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd1, 8'h10, 8'h22, 1'b0, 8'd5},
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd0, 8'h00, 8'h00, 1'b1, 8'd4},
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b1, 29'h36D, 4'd2, 8'h11, 8'h22, 1'b0, 8'd4},
    '{1'b1, 32'h6DB01122, 32'h00000000, 1'b0, 1'b1, 29'h36D, 4'd2, 8'h00, 8'h00, 1'b1, 8'd4},
    '{1'b1, 32'h6DAF1122, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd2, 8'h11, 8'h22, 1'b1, 8'd4},
    '{1'b1, 32'h6DA01122, 32'h00000000, 1'b0, 1'b0, 29'h36C, 4'd2, 8'h11, 8'h22, 1'b0, 8'd4},
    '{1'b1, 32'h6DA01122, 32'h0000FF00, 1'b0, 1'b0, 29'h36D, 4'd2, 8'h99, 8'h22, 1'b1, 8'd5},
    // R6 dual extended
    '{1'b0, 32'h12345678, 32'h00000000, 1'b1, 1'b0, 29'h02469ABC, 4'd0, 8'h00, 8'h00, 1'b1, 8'd6},
    '{1'b0, 32'h12345678, 32'h00000000, 1'b1, 1'b1, 29'h0ACF0000, 4'd0, 8'h00, 8'h00, 1'b1, 8'd6},
    '{1'b0, 32'h12345678, 32'h00000000, 1'b1, 1'b0, 29'h0246A000, 4'd0, 8'h00, 8'h00, 1'b0, 8'd6},
    '{1'b0, 32'h12345678, 32'h00FF0000, 1'b1, 1'b0, 29'h025FE000, 4'd0, 8'h00, 8'h00, 1'b1, 8'd6},
    // R7 / R8 dual standard
    '{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd1, 8'hC5, 8'h00, 1'b1, 8'd7},
    '{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd1, 8'h5C, 8'h00, 1'b0, 8'd7},
    '{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h36D, 4'd0, 8'h00, 8'h00, 1'b1, 8'd7},
    '{1'b0, 32'h6DAC4065, 32'h000F000F, 1'b0, 1'b0, 29'h36D, 4'd1, 8'h00, 8'h00, 1'b1, 8'd7},
    '{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h203, 4'd3, 8'h00, 8'h00, 1'b1, 8'd8},
    '{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b1, 29'h203, 4'd0, 8'h00, 8'h00, 1'b0, 8'd8},
    '{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h204, 4'd0, 8'h00, 8'h00, 1'b0, 8'd8},
    // R9 same bytes, single mode: standard ID 0x203 no longer matches
    '{1'b1, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h203, 4'd3, 8'h00, 8'h00, 1'b0, 8'd9}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic singleMode = 1'b0;
  logic [31:0] filtCode = '0, filtMask = '0;
  logic frameValid = 1'b0, frameExt = 1'b0, frameRtr = 1'b0;
  logic [28:0] frameId = '0;
  logic [3:0] frameDlc = '0;
  logic [7:0] frameData0 = '0, frameData1 = '0;
  logic verdictValid, verdictAccept;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter dut_i (
    .clk(clk), .rstN(rstN), .singleMode(singleMode),
    .filtCode(filtCode), .filtMask(filtMask),
    .frameValid(frameValid), .frameExt(frameExt), .frameRtr(frameRtr),
    .frameId(frameId), .frameDlc(frameDlc),
    .frameData0(frameData0), .frameData1(frameData1),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );

  task automatic check(input string tag, input logic expV, input logic expA);
    checks++;
    if (verdictValid !== expV || verdictAccept !== expA) begin
      fails++;
      $display("FAIL %s: valid/accept actual %b/%b expected %b/%b",
               tag, verdictValid, verdictAccept, expV, expA);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic runFrame(input vec_t v);
    @(negedge clk);
    singleMode = v.sm; filtCode = v.code; filtMask = v.mask;
    frameExt = v.ext; frameRtr = v.rtr; frameId = v.id;
    frameDlc = v.dlc; frameData0 = v.d0; frameData1 = v.d1;
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runFrame(VECS[i]);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 1'b1, VECS[i].exp);
    end

    // R1: verdict drops the cycle after the strobe goes low
    @(negedge clk);
    check("R1 idle after frame", 1'b0, 1'b0);

    // R1: a matching frame without a strobe gives no acceptance
    filtMask = '1; frameExt = 1'b1;
    @(negedge clk);
    check("R1 no strobe", 1'b0, 1'b0);

    // R2: all don't care accepts anything, single and dual
    runFrame('{1'b1, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b1, 29'h1FFFFFFF,
               4'd8, 8'hFF, 8'hFF, 1'b1, 8'd2});
    check("R2 all mask single", 1'b1, 1'b1);
    runFrame('{1'b0, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 29'h7FF,
               4'd2, 8'h3C, 8'hC3, 1'b1, 8'd2});
    check("R2 all mask dual", 1'b1, 1'b1);

    // R9: the dual-mode reading of the same bytes accepts
    runFrame('{1'b0, 32'h6DAC4065, 32'h00000000, 1'b0, 1'b0, 29'h203,
               4'd3, 8'h00, 8'h00, 1'b1, 8'd9});
    check("R9 dual reading", 1'b1, 1'b1);

    // R1: reset in the middle clears the verdict
    @(negedge clk);
    frameValid = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid", 1'b0, 1'b0);
    frameValid = 1'b0;
    rstN = 1'b1;

    finish();
  end
endmodule